// File: doc/BRIEF.md
# Command Stream Fetcher with Tag Skipping

The fetcher sits between a DMA-fed queue of 128-bit quadwords and a command executor. Each quadword arrives with one flag saying whether its two lowest 32-bit words are DMA tags. The fetcher keeps a read pointer made of a quadword slot and a word-within-quadword index. It presents the 32-bit command under that pointer and answers operand lookups of the form "the N-th operand word after the command", stepping over tag words. When the executor finishes a command, it asks the fetcher to move on by K words. The fetcher then frees every quadword it has fully passed.

The fetcher also owns the stall and status flags that gate issue. These are the interrupt flag, the interrupt stall, the force-break and stop-stall holds, and the two error flags. Every flag has its own mask behaviour. A command with its interrupt bit set is held back once. A loop guard stops it from raising the interrupt again after it resumes. Two helpers expand the 8-bit upload count and the 16-bit transfer count taken from the command immediate, where a zero field stands for the largest count.

Top module: `cmdf_fetch`

## Requirements
- R1: A quadword pushed with push_tag=1 has words 0 and 1 (bits [63:0]) treated as tag words. cmd_word is the first non-tag word at or after the pointer, and tag words are never counted.
- R2: With opnd_idx=N, opnd_word is the N-th non-tag word after the command word. opnd_tag is 1 when a tag word lies between the command and that operand.
- R3: If fewer than N non-tag words follow the command, opnd_ready is 0. An advance whose count is zero or larger than the available non-tag words is refused (adv_ready=0), and the pointer and queue stay unchanged.
- R4: An accepted advance by K makes the K-th non-tag word after the current command the new command, and releases every fully passed quadword.
- R5: not_empty (and cmd_valid) is 0 once the pointer has passed the last queued word.
- R6: When an accepted advance consumed a tag word lying between the command and its last consumed operand, st_err0 is set on the next cycle. st_istall is also set unless mask_err0 is 1. Tag words after the last operand and before the next command cause no error.
- R7: The command word carries an interrupt bit at bit 31 and an opcode at bits [30:24]. The mark opcode defaults to 7'h07. A new interrupt-flagged command sets st_int, and sets st_istall unless mask_int is 1. issue is 0 for that cycle unless the opcode is mark.
- R8: After the stall of an interrupt-flagged command is cleared, the same command issues without raising st_int again. The guard is released by the next accepted advance.
- R9: illegal=1 always sets st_err1. It sets st_istall only if mask_err1 is 0.
- R10: issue is 0 while st_brk, st_stop or st_istall is set. st_err0 and st_err1 alone do not block issue.
- R11: ctl_brk sets st_brk and ctl_stop sets st_stop. ctl_clear clears st_brk, st_stop, st_istall, st_int, st_err0 and st_err1, but not the loop guard.
- R12: upl_cnt equals cmd_word[7:0], or 256 when that field is 0. dir_cnt equals cmd_word[15:0], or 65536 when that field is 0.
- R13: push_ready is 0 while DEPTH quadwords are held, and a push is taken only when push_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Quadword offered by the DMA side |
| push_data | input | QW_W | Quadword, word w at bits [32w+31:32w] |
| push_tag | input | 1 | Words 0 and 1 of this quadword are DMA tags |
| push_ready | output | 1 | Queue has a free slot |
| cmd_valid | output | 1 | A command word is under the pointer |
| cmd_word | output | 32 | Current command word |
| issue | output | 1 | Command may execute this cycle |
| opnd_idx | input | IDX_W | Operand number to look up |
| opnd_ready | output | 1 | Requested operand is queued |
| opnd_word | output | 32 | Requested operand word |
| opnd_tag | output | 1 | A tag word lies between command and operand |
| adv_valid | input | 1 | Executor consumes adv_cnt words |
| adv_cnt | input | IDX_W | Words consumed, command included |
| adv_ready | output | 1 | Advance by adv_cnt can be taken |
| illegal | input | 1 | Executor found the command illegal |
| mask_int | input | 1 | Interrupt does not stall |
| mask_err0 | input | 1 | Tag mismatch does not stall |
| mask_err1 | input | 1 | Illegal command does not stall |
| ctl_clear | input | 1 | Clear stall and status flags |
| ctl_brk | input | 1 | Force break |
| ctl_stop | input | 1 | Stop stall |
| not_empty | output | 1 | Unconsumed words remain |
| st_int | output | 1 | Interrupt flag |
| st_istall | output | 1 | Interrupt stall |
| st_err0 | output | 1 | Tag mismatch error |
| st_err1 | output | 1 | Illegal command error |
| st_brk | output | 1 | Force break held |
| st_stop | output | 1 | Stop stall held |
| upl_cnt | output | 9 | Expanded upload pair count |
| dir_cnt | output | 17 | Expanded transfer quadword count |

## Verification
The outputs cmd_word, opnd_ready, opnd_word, opnd_tag, adv_ready, issue and the count expansions follow the inputs and the current state with no delay. The bench reads them one nanosecond after it drives inputs in the low clock phase. Pointer moves, pushes and every status flag take one rising edge, so those results are read at the falling edge after the edge that took the stimulus. Every tag pattern over four quadwords is swept against every operand index, and the expected words, readiness and tag-crossing bits come from a list model built in the bench.

// File: rtl/cmdf_pkg.sv
package cmdf_pkg;

    localparam int WORD_W    = 32;
    localparam int TAG_WORDS = 2;
    localparam int IRQ_BIT   = 31;
    localparam int OPC_LSB   = 24;
    localparam int OPC_W     = 7;

    typedef struct packed {
        logic brk;
        logic stop;
        logic istall;
        logic intf;
        logic err0;
        logic err1;
        logic guard;
    } flags_t;

    function automatic logic [8:0] upload_pairs(input logic [7:0] f);
        return (f == 8'd0) ? 9'd256 : {1'b0, f};
    endfunction

    function automatic logic [16:0] direct_qws(input logic [15:0] f);
        return (f == 16'd0) ? 17'd65536 : {1'b0, f};
    endfunction

endpackage

// File: rtl/cmdf_store.sv
module cmdf_store #(
    parameter int DEPTH = 4,
    parameter int QW_W  = 128,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_en,
    input  logic [QW_W-1:0]        push_data,
    input  logic                   push_tag,
    input  logic [CNT_W-1:0]       pop_n,
    output logic [DEPTH*QW_W-1:0]  mem_flat,
    output logic [DEPTH-1:0]       tag_vec,
    output logic [PTR_W-1:0]       rd,
    output logic [CNT_W-1:0]       cnt
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [QW_W-1:0]  mem_q [DEPTH];
    logic [DEPTH-1:0] tag_q;

    always_comb begin
        st_d     = st_q;
        st_d.rd  = st_q.rd + PTR_W'(pop_n);
        st_d.cnt = st_q.cnt - pop_n + CNT_W'(push_en);
        if (push_en) begin
            st_d.wr = st_q.wr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            tag_q <= '0;
        end else begin
            st_q <= st_d;
            if (push_en) begin
                tag_q[st_q.wr] <= push_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) begin
            mem_q[st_q.wr] <= push_data;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign mem_flat[i*QW_W +: QW_W] = mem_q[i];
    end

    assign tag_vec = tag_q;
    assign rd      = st_q.rd;
    assign cnt     = st_q.cnt;

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (st_q.cnt < CNT_W'(DEPTH)));

    p_pop_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n <= st_q.cnt);

endmodule

// File: rtl/cmdf_locate.sv
module cmdf_locate
    import cmdf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int QW_W  = 128,
    localparam int WPQ    = QW_W / WORD_W,
    localparam int SLOTS  = DEPTH * WPQ,
    localparam int IDX_W  = $clog2(SLOTS + 1),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int WSEL_W = $clog2(WPQ)
) (
    input  logic [DEPTH*QW_W-1:0] mem_flat,
    input  logic [DEPTH-1:0]      tag_vec,
    input  logic [PTR_W-1:0]      rd,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [WSEL_W-1:0]     wd,
    input  logic [IDX_W-1:0]      qry,
    output logic                  found,
    output logic [IDX_W-1:0]      pos,
    output logic [WORD_W-1:0]     word,
    output logic                  tag_upto,
    output logic                  tag_below,
    output logic [IDX_W-1:0]      tot
);

    // Walk the slots in stream order from the raw pointer; a non-tag word
    // takes the next ordinal, a tag word remembers how many came before it.
    always_comb begin
        int ord;
        ord       = 0;
        found     = 1'b0;
        pos       = '0;
        word      = '0;
        tag_upto  = 1'b0;
        tag_below = 1'b0;
        for (int j = 0; j < SLOTS; j++) begin
            int abs_w;
            int qoff;
            int wsel;
            int qslot;
            logic valid;
            logic is_tag;
            abs_w  = int'(wd) + j;
            qoff   = abs_w / WPQ;
            wsel   = abs_w % WPQ;
            qslot  = (int'(rd) + qoff) % DEPTH;
            valid  = (qoff < int'(cnt));
            is_tag = valid && tag_vec[qslot] && (wsel < TAG_WORDS);
            if (valid) begin
                if (is_tag) begin
                    if (ord >= 1 && ord <= int'(qry)) tag_upto  = 1'b1;
                    if (ord >= 1 && ord <  int'(qry)) tag_below = 1'b1;
                end else begin
                    if (ord == int'(qry) && !found) begin
                        found = 1'b1;
                        pos   = IDX_W'(j);
                        word  = mem_flat[qslot*QW_W + wsel*WORD_W +: WORD_W];
                    end
                    ord = ord + 1;
                end
            end
        end
        tot = IDX_W'(ord);
    end

endmodule

// File: rtl/cmdf_ctrl.sv
module cmdf_ctrl
    import cmdf_pkg::*;
#(
    parameter logic [OPC_W-1:0] MARK_OPC = 7'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_irq,
    input  logic [OPC_W-1:0] cmd_opc,
    input  logic             adv_acc,
    input  logic             adv_tag,
    input  logic             illegal,
    input  logic             mask_int,
    input  logic             mask_err0,
    input  logic             mask_err1,
    input  logic             ctl_clear,
    input  logic             ctl_brk,
    input  logic             ctl_stop,
    output logic             issue,
    output flags_t           flags
);

    flags_t fl_d, fl_q;
    logic   blocked;
    logic   new_irq;
    logic   is_mark;

    always_comb begin
        fl_d    = fl_q;
        blocked = fl_q.brk | fl_q.stop | fl_q.istall;
        is_mark = (cmd_opc == MARK_OPC);
        new_irq = cmd_valid && !blocked && cmd_irq && !fl_q.guard;
        issue   = cmd_valid && !blocked && !(new_irq && !is_mark);

        // clear first, then the set requests of the same cycle
        if (ctl_clear) begin
            fl_d.brk    = 1'b0;
            fl_d.stop   = 1'b0;
            fl_d.istall = 1'b0;
            fl_d.intf   = 1'b0;
            fl_d.err0   = 1'b0;
            fl_d.err1   = 1'b0;
        end
        if (ctl_stop) fl_d.stop = 1'b1;
        if (ctl_brk)  fl_d.brk  = 1'b1;
        if (new_irq) begin
            fl_d.intf  = 1'b1;
            fl_d.guard = 1'b1;
            if (!mask_int) fl_d.istall = 1'b1;
        end
        if (adv_acc) begin
            fl_d.guard = 1'b0;
            if (adv_tag) begin
                fl_d.err0 = 1'b1;
                if (!mask_err0) fl_d.istall = 1'b1;
            end
        end
        if (illegal) begin
            fl_d.err1 = 1'b1;
            if (!mask_err1) fl_d.istall = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    p_err1_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> fl_q.err1);

    p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        new_irq |=> fl_q.intf);

    p_brk_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_brk |=> !issue);

    p_err0_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_acc && adv_tag) |=> fl_q.err0);

endmodule

// File: rtl/cmdf_fetch.sv
module cmdf_fetch
    import cmdf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int QW_W  = 128,
    parameter logic [OPC_W-1:0] MARK_OPC = 7'h07,
    localparam int WPQ    = QW_W / WORD_W,
    localparam int SLOTS  = DEPTH * WPQ,
    localparam int IDX_W  = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [QW_W-1:0]  push_data,
    input  logic             push_tag,
    output logic             push_ready,
    output logic             cmd_valid,
    output logic [31:0]      cmd_word,
    output logic             issue,
    input  logic [IDX_W-1:0] opnd_idx,
    output logic             opnd_ready,
    output logic [31:0]      opnd_word,
    output logic             opnd_tag,
    input  logic             adv_valid,
    input  logic [IDX_W-1:0] adv_cnt,
    output logic             adv_ready,
    input  logic             illegal,
    input  logic             mask_int,
    input  logic             mask_err0,
    input  logic             mask_err1,
    input  logic             ctl_clear,
    input  logic             ctl_brk,
    input  logic             ctl_stop,
    output logic             not_empty,
    output logic             st_int,
    output logic             st_istall,
    output logic             st_err0,
    output logic             st_err1,
    output logic             st_brk,
    output logic             st_stop,
    output logic [8:0]       upl_cnt,
    output logic [16:0]      dir_cnt
);

    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int WSEL_W = $clog2(WPQ);

    typedef struct packed {
        logic [WSEL_W-1:0] wd;
    } fx_t;

    fx_t fx_d, fx_q;

    logic [DEPTH*QW_W-1:0] mem_flat;
    logic [DEPTH-1:0]      tag_vec;
    logic [PTR_W-1:0]      rd;
    logic [CNT_W-1:0]      cnt;
    logic [CNT_W-1:0]      pop_n;
    logic                  push_acc;
    logic                  adv_acc;
    logic [WSEL_W-1:0]     hsel;
    flags_t                flags;

    logic             op_found, op_tag_below;
    logic [IDX_W-1:0] op_pos, op_tot;
    logic             av_found, av_tag_upto, av_tag_below;
    logic [IDX_W-1:0] av_pos, av_tot;
    logic [31:0]      av_word;

    assign push_ready = (cnt < CNT_W'(DEPTH));
    assign push_acc   = push_valid && push_ready;

    cmdf_store #(.DEPTH(DEPTH), .QW_W(QW_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_acc),
        .push_data (push_data),
        .push_tag  (push_tag),
        .pop_n     (pop_n),
        .mem_flat  (mem_flat),
        .tag_vec   (tag_vec),
        .rd        (rd),
        .cnt       (cnt)
    );

    cmdf_locate #(.DEPTH(DEPTH), .QW_W(QW_W)) u_opnd (
        .mem_flat  (mem_flat),
        .tag_vec   (tag_vec),
        .rd        (rd),
        .cnt       (cnt),
        .wd        (fx_q.wd),
        .qry       (opnd_idx),
        .found     (op_found),
        .pos       (op_pos),
        .word      (opnd_word),
        .tag_upto  (opnd_tag),
        .tag_below (op_tag_below),
        .tot       (op_tot)
    );

    cmdf_locate #(.DEPTH(DEPTH), .QW_W(QW_W)) u_adv (
        .mem_flat  (mem_flat),
        .tag_vec   (tag_vec),
        .rd        (rd),
        .cnt       (cnt),
        .wd        (fx_q.wd),
        .qry       (adv_cnt),
        .found     (av_found),
        .pos       (av_pos),
        .word      (av_word),
        .tag_upto  (av_tag_upto),
        .tag_below (av_tag_below),
        .tot       (av_tot)
    );

    logic unused_sink;
    assign unused_sink = ^{op_pos, op_tag_below, av_word, av_tag_upto};

    assign opnd_ready = op_found;
    assign adv_ready  = (adv_cnt != '0) && (adv_cnt <= av_tot);
    assign adv_acc    = adv_valid && adv_ready;

    // pointer update: land on the K-th non-tag word, or past the end
    always_comb begin
        int abs_w;
        fx_d  = fx_q;
        pop_n = '0;
        abs_w = 0;
        if (adv_acc) begin
            if (av_found) abs_w = int'(fx_q.wd) + int'(av_pos);
            else          abs_w = int'(cnt) * WPQ;
            pop_n   = CNT_W'(abs_w / WPQ);
            fx_d.wd = WSEL_W'(abs_w % WPQ);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fx_q <= '0;
        else        fx_q <= fx_d;
    end

    // command word: step over the leading tag words of the head quadword
    always_comb begin
        if (tag_vec[rd] && (int'(fx_q.wd) < TAG_WORDS)) hsel = WSEL_W'(TAG_WORDS);
        else                                             hsel = fx_q.wd;
        cmd_valid = (cnt != '0);
        cmd_word  = '0;
        if (cmd_valid) begin
            cmd_word = mem_flat[int'(rd)*QW_W + int'(hsel)*WORD_W +: WORD_W];
        end
    end

    assign not_empty = cmd_valid;
    assign upl_cnt   = upload_pairs(cmd_word[7:0]);
    assign dir_cnt   = direct_qws(cmd_word[15:0]);

    cmdf_ctrl #(.MARK_OPC(MARK_OPC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_irq   (cmd_word[IRQ_BIT]),
        .cmd_opc   (cmd_word[OPC_LSB +: OPC_W]),
        .adv_acc   (adv_acc),
        .adv_tag   (av_tag_below),
        .illegal   (illegal),
        .mask_int  (mask_int),
        .mask_err0 (mask_err0),
        .mask_err1 (mask_err1),
        .ctl_clear (ctl_clear),
        .ctl_brk   (ctl_brk),
        .ctl_stop  (ctl_stop),
        .issue     (issue),
        .flags     (flags)
    );

    assign st_int    = flags.intf;
    assign st_istall = flags.istall;
    assign st_err0   = flags.err0;
    assign st_err1   = flags.err1;
    assign st_brk    = flags.brk;
    assign st_stop   = flags.stop;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_acc |=> ($stable(fx_q.wd) && $stable(rd)));

    p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_acc && (adv_cnt == av_tot) && !push_acc) |=> !not_empty);

    p_ready_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_ready |-> (opnd_idx < op_tot));

endmodule

// File: tb/tb_cmdf_fetch.sv
module tb_cmdf_fetch;

    localparam int DEPTH = 4;
    localparam int QW_W  = 128;
    localparam int IDX_W = $clog2(DEPTH * 4 + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0;
    logic [QW_W-1:0]  push_data = '0;
    logic             push_tag = 1'b0;
    logic             push_ready;
    logic             cmd_valid;
    logic [31:0]      cmd_word;
    logic             issue;
    logic [IDX_W-1:0] opnd_idx = '0;
    logic             opnd_ready;
    logic [31:0]      opnd_word;
    logic             opnd_tag;
    logic             adv_valid = 1'b0;
    logic [IDX_W-1:0] adv_cnt = '0;
    logic             adv_ready;
    logic illegal = 1'b0, mask_int = 1'b0, mask_err0 = 1'b0, mask_err1 = 1'b0;
    logic ctl_clear = 1'b0, ctl_brk = 1'b0, ctl_stop = 1'b0;
    logic not_empty, st_int, st_istall, st_err0, st_err1, st_brk, st_stop;
    logic [8:0]  upl_cnt;
    logic [16:0] dir_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cmdf_fetch #(.DEPTH(DEPTH), .QW_W(QW_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data), .push_tag(push_tag),
        .push_ready(push_ready),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .issue(issue),
        .opnd_idx(opnd_idx), .opnd_ready(opnd_ready), .opnd_word(opnd_word),
        .opnd_tag(opnd_tag),
        .adv_valid(adv_valid), .adv_cnt(adv_cnt), .adv_ready(adv_ready),
        .illegal(illegal), .mask_int(mask_int), .mask_err0(mask_err0),
        .mask_err1(mask_err1), .ctl_clear(ctl_clear), .ctl_brk(ctl_brk),
        .ctl_stop(ctl_stop),
        .not_empty(not_empty), .st_int(st_int), .st_istall(st_istall),
        .st_err0(st_err0), .st_err1(st_err1), .st_brk(st_brk), .st_stop(st_stop),
        .upl_cnt(upl_cnt), .dir_cnt(dir_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_qw(input logic [127:0] d, input logic t);
        push_valid = 1'b1; push_data = d; push_tag = t;
        tick();
        push_valid = 1'b0;
    endtask

    task automatic adv(input int k);
        adv_valid = 1'b1; adv_cnt = IDX_W'(k);
        tick();
        adv_valid = 1'b0;
    endtask

    task automatic pulse_clear;
        ctl_clear = 1'b1;
        tick();
        ctl_clear = 1'b0;
    endtask

    function automatic logic [127:0] qw(input logic [31:0] w0, input logic [31:0] w1,
                                        input logic [31:0] w2, input logic [31:0] w3);
        return {w3, w2, w1, w0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] TG = 32'hDEAD_BEEF;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        chk("R5 reset not_empty", {31'd0, not_empty}, 0);
        chk("R13 reset push_ready", {31'd0, push_ready}, 1);
        chk("R11 reset flags", {26'd0, st_int, st_istall, st_err0, st_err1, st_brk, st_stop}, 0);
        chk("R10 reset issue", {31'd0, issue}, 0);

        // R1 R2 R4: tagged head quadword
        push_qw(qw(TG, TG, 32'h0100_0001, 32'h0000_00D1), 1'b1);
        push_qw(qw(32'h0000_00D2, 32'h0000_00D3, 32'h0100_0002, 32'h0000_00D4), 1'b0);
        #1;
        chk("R1 cmd skips tags", cmd_word, 32'h0100_0001);
        opnd_idx = 1; #1;
        chk("R2 operand 1", opnd_word, 32'h0000_00D1);
        chk("R2 operand 1 no tag", {31'd0, opnd_tag}, 0);
        opnd_idx = 3; #1;
        chk("R2 operand 3", opnd_word, 32'h0000_00D3);
        adv(4); #1;
        chk("R4 next command", cmd_word, 32'h0100_0002);
        chk("R4 head released", {31'd0, push_ready}, 1);
        opnd_idx = 2; #1;
        chk("R3 operand not ready", {31'd0, opnd_ready}, 0);
        adv_cnt = 3; #1;
        chk("R3 adv_ready low", {31'd0, adv_ready}, 0);
        adv(3); #1;
        chk("R3 pointer unchanged", cmd_word, 32'h0100_0002);

        // R6: tag between command and operand
        push_qw(qw(TG, TG, 32'h0000_00D5, 32'h0100_0003), 1'b1);
        opnd_idx = 1; #1;
        chk("R2 operand 1 before tag", opnd_word, 32'h0000_00D4);
        chk("R2 no tag before", {31'd0, opnd_tag}, 0);
        opnd_idx = 2; #1;
        chk("R2 operand across tag", opnd_word, 32'h0000_00D5);
        chk("R2 tag crossed", {31'd0, opnd_tag}, 1);
        adv(3); #1;
        chk("R6 err0 set", {31'd0, st_err0}, 1);
        chk("R6 istall set", {31'd0, st_istall}, 1);
        chk("R10 istall blocks", {31'd0, issue}, 0);
        chk("R4 cmd after tag", cmd_word, 32'h0100_0003);
        pulse_clear(); #1;
        chk("R11 err0 cleared", {30'd0, st_err0, st_istall}, 0);
        chk("R10 issue resumes", {31'd0, issue}, 1);

        // R6: tags just before next command are not an error
        push_qw(qw(TG, TG, 32'h0100_0004, 32'h0000_00D6), 1'b1);
        adv(1); #1;
        chk("R6 no err on leading tags", {31'd0, st_err0}, 0);
        chk("R1 cmd after tag pair", cmd_word, 32'h0100_0004);

        // R6 masked
        mask_err0 = 1'b1;
        push_qw(qw(TG, TG, 32'h0000_00D7, 32'h0100_0005), 1'b1);
        adv(3); #1;
        chk("R6 masked err0 set", {31'd0, st_err0}, 1);
        chk("R6 masked no istall", {31'd0, st_istall}, 0);
        chk("R10 err0 alone no block", {31'd0, issue}, 1);
        mask_err0 = 1'b0;
        pulse_clear();
        adv(1); #1;
        chk("R5 drained", {30'd0, not_empty, cmd_valid}, 0);

        // R7 R8 interrupts
        push_qw(qw(32'h8100_0001, 32'h8700_0000, 32'h8100_0002, 32'h0100_0003), 1'b0);
        #1;
        chk("R7 irq suspends", {31'd0, issue}, 0);
        tick(); #1;
        chk("R7 int and istall", {30'd0, st_int, st_istall}, 3);
        chk("R7 held", {31'd0, issue}, 0);
        pulse_clear(); #1;
        chk("R8 resumes", {31'd0, issue}, 1);
        tick(); #1;
        chk("R8 no re-raise", {30'd0, st_int, st_istall}, 0);
        adv(1); #1;
        chk("R7 mark issues at once", {31'd0, issue}, 1);
        tick(); #1;
        chk("R7 mark raises stall", {30'd0, st_int, st_istall}, 3);
        pulse_clear();
        mask_int = 1'b1;
        adv(1); #1;
        chk("R7 masked irq suspends", {31'd0, issue}, 0);
        tick(); #1;
        chk("R7 masked int only", {30'd0, st_int, st_istall}, 2);
        chk("R8 masked resumes", {31'd0, issue}, 1);
        mask_int = 1'b0;
        pulse_clear();
        adv(1);
        adv(1); #1;
        chk("R5 drained 2", {31'd0, not_empty}, 0);

        // R9 illegal
        illegal = 1'b1; tick(); illegal = 1'b0; #1;
        chk("R9 err1 and stall", {30'd0, st_err1, st_istall}, 3);
        pulse_clear();
        mask_err1 = 1'b1;
        illegal = 1'b1; tick(); illegal = 1'b0; #1;
        chk("R9 masked err1 only", {30'd0, st_err1, st_istall}, 2);
        mask_err1 = 1'b0;
        pulse_clear();

        // R10 R11 R12
        push_qw(qw(32'h0100_0000, 32'h0100_1234, 32'h0100_0005, 32'h0100_0006), 1'b0);
        #1;
        chk("R12 upload zero", {23'd0, upl_cnt}, 256);
        chk("R12 direct zero", {15'd0, dir_cnt}, 65536);
        chk("R10 err1 alone no block", {31'd0, issue}, 1);
        ctl_brk = 1'b1; tick(); ctl_brk = 1'b0; #1;
        chk("R11 brk set", {31'd0, st_brk}, 1);
        chk("R10 brk blocks", {31'd0, issue}, 0);
        pulse_clear(); #1;
        chk("R10 brk cleared", {30'd0, st_brk, issue}, 1);
        ctl_stop = 1'b1; tick(); ctl_stop = 1'b0; #1;
        chk("R11 stop set", {31'd0, st_stop}, 1);
        chk("R10 stop blocks", {31'd0, issue}, 0);
        pulse_clear();
        adv(1); #1;
        chk("R12 upload field", {23'd0, upl_cnt}, 32'h34);
        chk("R12 direct field", {15'd0, dir_cnt}, 32'h1234);
        adv(3);

        // sweep every tag pattern over four quadwords and every operand index
        for (int pat = 0; pat < 16; pat++) begin
            logic [31:0] lw [16];
            logic        lt [16];
            int tot;
            for (int q = 0; q < 4; q++) begin
                logic [31:0] w [4];
                for (int k = 0; k < 4; k++) w[k] = 32'h0100_0000 | (pat << 8) | (q << 4) | k;
                push_qw(qw(w[0], w[1], w[2], w[3]), pat[q]);
                for (int k = 0; k < 4; k++) begin
                    lw[q*4+k] = w[k];
                    lt[q*4+k] = pat[q] && (k < 2);
                end
            end
            #1;
            chk("R13 full", {31'd0, push_ready}, 0);
            tot = 0;
            for (int s = 0; s < 16; s++) if (!lt[s]) tot++;
            for (int n = 0; n < 16; n++) begin
                int ord;
                logic [31:0] ew;
                logic        et;
                ord = 0; ew = '0; et = 1'b0;
                for (int s = 0; s < 16; s++) begin
                    if (lt[s]) begin
                        if (ord >= 1 && ord <= n) et = 1'b1;
                    end else begin
                        if (ord == n) ew = lw[s];
                        ord++;
                    end
                end
                opnd_idx = IDX_W'(n); #1;
                chk("R3 sweep ready", {31'd0, opnd_ready}, (n < tot) ? 1 : 0);
                if (n < tot) begin
                    chk("R2 sweep word", opnd_word, ew);
                    chk("R2 sweep tag", {31'd0, opnd_tag}, {31'd0, et});
                end
                if (n == 0) chk("R1 sweep cmd", cmd_word, ew);
            end
            adv(tot); #1;
            chk("R5 sweep drained", {31'd0, not_empty}, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule